// File: doc/BRIEF.md
# Eight-bit Compare Timer with Square-Wave Divider

This block is an 8-bit up-counter paired with a compare register. Each time the counter reaches the compare value it clears itself and pulses an interrupt request for one clock. The count can advance on one of several internal tick enables, selected by a source field, or on qualified falling edges of an external event input. In divider mode every compare match also flips a timer flip-flop, and its inverse is driven onto a pin. The result is a 50% duty square wave whose half-period is the compare value in ticks.

Software controls the block through a run bit, a mode field, a compare write port and a flip-flop preset. In the two internal-clock modes, a compare value written while the timer runs waits in a holding register until the next match, so the period in progress is never cut short. In event mode a write takes effect at once. The external input passes through a synchronizer and a level-width filter before any edge is counted.

Top module: `tmr8_divider`

## Requirements
- R1: When an advance brings the counter to the active compare value, `irq` is high for exactly the following clock and the counter restarts from 0. With an active compare value C, there is one `irq` per C advances.
- R2: An active compare value of 0 counts as 256, so one `irq` occurs per 256 advances.
- R3: In timer and divider modes the counter advances only on cycles where `tick_in[src_sel]` is high. Ticks on the unselected lines have no effect on `irq` or `div_out`.
- R4: In event mode (`mode` = 2'b01) the counter advances once for each falling edge of `evt_in`. Before the edge counts, `evt_in` must have been high for at least two consecutive clocks and must then stay low for at least two consecutive clocks, as seen after a two-flop synchronizer. A high pulse of one clock is ignored.
- R5: In event mode, a compare write while running takes effect at the very next advance.
- R6: In timer and divider modes, a compare write while running is held until the next match and only then becomes active. While `run` is low, a written value becomes active within two clocks.
- R7: In divider mode (`mode` = 2'b10) each match inverts the timer flip-flop. `div_out` is always the inverse of that flip-flop, and after reset it is 1.
- R8: A cycle with `ff_wr` high loads `ff_val` into the timer flip-flop in timer and divider modes. In event mode the preset is ignored and `div_out` does not change.
- R9: While `run` is low the counter is held at 0, `irq` stays low and `div_out` keeps its level. Counting resumes from 0 when `run` returns high.
- R10: Mode 2'b00 (timer) and the spare code 2'b11 count internal ticks and never toggle the flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 timer, 01 event, 10 divider, 11 same as timer |
| src_sel | input | SELW (2) | Index of the tick enable counted in internal modes |
| tick_in | input | NSRC (4) | Internal tick enables, one clock wide each |
| run | input | 1 | 1 counts, 0 stops and clears the counter |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_data | input | 8 | Compare value to write |
| ff_wr | input | 1 | Flip-flop preset strobe |
| ff_val | input | 1 | Value to preset into the flip-flop |
| evt_in | input | 1 | Asynchronous external event input |
| irq | output | 1 | One-clock match pulse |
| div_out | output | 1 | Inverse of the timer flip-flop |

## Verification
The hardest state to reach is a compare write landing in the middle of a period. In event mode the new value must cut the period short. In timer mode it must wait for the old value to finish. The bench reaches this state by stopping the timer, loading a known compare value, and driving an exact number of ticks or clean edges. It then writes the new value and counts the further advances needed before the next `irq`. The event filter is tested by sending one-clock glitches between clean edges and checking that the number of edges to the next match does not change.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_EVENT  = 2'b01,
    MODE_DIVIDE = 2'b10,
    MODE_SPARE  = 2'b11
  } mode_e;

  localparam int CNT_W = 8;
endpackage

// File: rtl/tmr8_srcsel.sv
module tmr8_srcsel #(
  parameter int NSRC = 4,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [SELW-1:0] sel,
  input  logic [NSRC-1:0] tick_in,
  output logic            tick
);
  logic [NSRC-1:0] hit_vec;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit_vec[g] = tick_in[g] & (sel == SELW'(g));
  end

  assign tick = |hit_vec;
endmodule

// File: rtl/tmr8_evq.sv
module tmr8_evq #(
  parameter int MIN_LVL = 2,
  localparam int LW = $clog2(MIN_LVL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic fall
);
  logic          s1_q, s2_q;
  logic          last_q, last_n;
  logic [LW-1:0] len_q, len_n;
  logic          arm_q, arm_n;
  logic          fall_q, fall_n;
  logic          same, reach;

  always_comb begin
    same   = (s2_q == last_q);
    last_n = s2_q;
    if (!same)
      len_n = LW'(1);
    else if (len_q == LW'(MIN_LVL))
      len_n = len_q;
    else
      len_n = len_q + LW'(1);
    reach  = same && (len_q == LW'(MIN_LVL - 1));
    arm_n  = arm_q;
    fall_n = 1'b0;
    if (reach && last_q)
      arm_n = 1'b1;
    else if (reach && !last_q) begin
      fall_n = arm_q;
      arm_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      last_q <= 1'b0;
      len_q  <= '0;
      arm_q  <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      s1_q   <= evt_in;
      s2_q   <= s1_q;
      last_q <= last_n;
      len_q  <= len_n;
      arm_q  <= arm_n;
      fall_q <= fall_n;
    end
  end

  assign fall = fall_q;

  // R4: an accepted edge is only reported once the filtered level is low
  assert_fall_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> !last_q);
  // R4: one edge per high-then-low sequence, never two in a row
  assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |=> !fall_q);
endmodule

// File: rtl/tmr8_cmpreg.sv
module tmr8_cmpreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         evt_mode,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] hold_q, hold_n;
  logic [W-1:0] act_q, act_n;

  always_comb begin
    hold_n = wr ? wdata : hold_q;
    act_n  = act_q;
    if (evt_mode) begin
      if (wr) act_n = wdata;
    end else if (load) begin
      act_n = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      hold_q <= hold_n;
      act_q  <= act_n;
    end
  end

  assign active = act_q;

  // R5: event-mode write is in force on the next clock
  assert_evt_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && evt_mode) |=> (act_q == $past(wdata)));
  // R6: internal modes keep the active value until a match or a stop
  assert_buffered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_mode && !load) |=> $stable(act_q));
endmodule

// File: rtl/tmr8_divider.sv
module tmr8_divider #(
  parameter int NSRC    = 4,
  parameter int MIN_LVL = 2,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int W    = tmr8_pkg::CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [SELW-1:0] src_sel,
  input  logic [NSRC-1:0] tick_in,
  input  logic            run,
  input  logic            cmp_wr,
  input  logic [W-1:0]    cmp_data,
  input  logic            ff_wr,
  input  logic            ff_val,
  input  logic            evt_in,
  output logic            irq,
  output logic            div_out
);
  import tmr8_pkg::*;

  mode_e        md;
  logic         is_evt, is_div;
  logic         int_tick, evt_fall, adv, hit;
  logic [W-1:0] cmp_act;
  logic [W-1:0] cnt_q, cnt_n, cnt_inc;
  logic         irq_q, irq_n;
  logic         ff_q, ff_n;

  assign md     = mode_e'(mode);
  assign is_evt = (md == MODE_EVENT);
  assign is_div = (md == MODE_DIVIDE);

  tmr8_srcsel #(.NSRC(NSRC)) u_src (
    .sel     (src_sel),
    .tick_in (tick_in),
    .tick    (int_tick)
  );

  tmr8_evq #(.MIN_LVL(MIN_LVL)) u_evq (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_in),
    .fall   (evt_fall)
  );

  tmr8_cmpreg #(.W(W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cmp_wr),
    .wdata    (cmp_data),
    .evt_mode (is_evt),
    .load     (hit || !run),
    .active   (cmp_act)
  );

  assign adv     = run && (is_evt ? evt_fall : int_tick);
  assign cnt_inc = cnt_q + W'(1);
  assign hit     = adv && (cnt_inc == cmp_act);

  always_comb begin
    cnt_n = cnt_q;
    irq_n = 1'b0;
    ff_n  = ff_q;
    if (!run)
      cnt_n = '0;
    else if (adv) begin
      cnt_n = hit ? '0 : cnt_inc;
      irq_n = hit;
    end
    if (ff_wr && !is_evt)
      ff_n = ff_val;
    else if (hit && is_div)
      ff_n = ~ff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      ff_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      irq_q <= irq_n;
      ff_q  <= ff_n;
    end
  end

  assign irq     = irq_q;
  assign div_out = ~ff_q;

  // R1: a match leaves the counter at zero alongside the request
  assert_match_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == '0));
  // R9: a stopped timer is cleared and silent
  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!irq_q && cnt_q == '0));
  // R9: a stopped timer keeps its pin level unless preset
  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ff_wr) |=> $stable(div_out));
  // R7: in divider mode each match flips the pin
  assert_div_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && is_div && !ff_wr) |=> (div_out != $past(div_out)));
  // R8: preset is ignored in event mode
  assert_evt_no_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_evt |=> $stable(div_out));
endmodule

// File: tb/tmr8_divider_test.sv
module tmr8_divider_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [1:0] src_sel;
  logic [3:0] tick_in;
  logic       run, cmp_wr, ff_wr, ff_val, evt_in;
  logic [7:0] cmp_data;
  logic       irq, div_out;

  int tests = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr8_divider uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .src_sel(src_sel),
    .tick_in(tick_in), .run(run), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
    .ff_wr(ff_wr), .ff_val(ff_val), .evt_in(evt_in),
    .irq(irq), .div_out(div_out)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] src;
    logic [7:0] cmp;
    logic [9:0] n;
    logic [1:0] gap;
    logic [3:0] exp_irq;
    logic       exp_div;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd0, 8'd5,   10'd20,  2'd0, 4'd4, 1'b1},
    '{2'd0, 2'd1, 8'd3,   10'd10,  2'd2, 4'd3, 1'b1},
    '{2'd2, 2'd2, 8'd4,   10'd24,  2'd1, 4'd6, 1'b1},
    '{2'd2, 2'd0, 8'd7,   10'd21,  2'd0, 4'd3, 1'b0},
    '{2'd0, 2'd3, 8'd0,   10'd512, 2'd0, 4'd2, 1'b1},
    '{2'd2, 2'd1, 8'd1,   10'd5,   2'd1, 4'd5, 1'b0},
    '{2'd3, 2'd0, 8'd2,   10'd9,   2'd0, 4'd4, 1'b1},
    '{2'd0, 2'd3, 8'd255, 10'd300, 2'd0, 4'd1, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // selected line pulses once per advance; other lines always high (noise)
  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_in = ~(4'b0001 << src_sel) | (4'b0001 << src_sel);
      for (int j = 0; j < gap; j++) begin
        @(negedge clk);
        tick_in = ~(4'b0001 << src_sel);
      end
    end
    @(negedge clk);
    tick_in = 4'b0000;
  endtask

  task automatic write_cmp(input logic [7:0] v);
    @(negedge clk);
    cmp_wr = 1'b1; cmp_data = v;
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic preset(input logic v);
    @(negedge clk);
    ff_wr = 1'b1; ff_val = v;
    @(negedge clk);
    ff_wr = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] s, input logic [7:0] c);
    @(negedge clk);
    run = 1'b0; mode = 2'b00;
    preset(1'b0);
    write_cmp(c);
    idle(2);
    mode = m; src_sel = s;
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic evt_pulse(input int hi, input int lo);
    for (int i = 0; i < hi; i++) begin @(negedge clk); evt_in = 1'b1; end
    for (int i = 0; i < lo; i++) begin @(negedge clk); evt_in = 1'b0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic lvl;
    rst_n = 1'b0; mode = 2'b00; src_sel = 2'd0; tick_in = 4'b0; run = 1'b0;
    cmp_wr = 1'b0; cmp_data = 8'd0; ff_wr = 1'b0; ff_val = 1'b0; evt_in = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    check("R7 reset div_out", int'(div_out), 1);
    check("R9 reset irq", int'(irq), 0);

    // vector walk: R1 R2 R3 R7 R10
    for (int v = 0; v < 8; v++) begin
      setup(VECS[v].mode, VECS[v].src, VECS[v].cmp);
      base = irq_cnt;
      ticks(int'(VECS[v].n), int'(VECS[v].gap));
      idle(3);
      check($sformatf("R1/R2/R3 vec%0d irq count", v), irq_cnt - base, int'(VECS[v].exp_irq));
      check($sformatf("R7/R10 vec%0d div_out", v), int'(div_out), int'(VECS[v].exp_div));
      @(negedge clk); run = 1'b0;
    end

    // R6: buffered compare in timer mode
    setup(2'b00, 2'd0, 8'd4);
    base = irq_cnt;
    ticks(2, 0);
    write_cmp(8'd8);
    ticks(2, 0); idle(3);
    check("R6 old compare finishes period", irq_cnt - base, 1);
    ticks(7, 0); idle(3);
    check("R6 new compare not yet matched", irq_cnt - base, 1);
    ticks(1, 0); idle(3);
    check("R6 new compare after match", irq_cnt - base, 2);

    // R9: stop holds and clears
    setup(2'b10, 2'd1, 8'd3);
    base = irq_cnt;
    ticks(2, 0);
    @(negedge clk); run = 1'b0;
    lvl = div_out;
    ticks(10, 0); idle(2);
    check("R9 no irq while stopped", irq_cnt - base, 0);
    check("R9 div_out held while stopped", int'(div_out), int'(lvl));
    @(negedge clk); run = 1'b1;
    ticks(2, 0); idle(3);
    check("R9 restart from zero", irq_cnt - base, 0);
    ticks(1, 0); idle(3);
    check("R9 match after restart", irq_cnt - base, 1);
    check("R7 toggle after match", int'(div_out), 0);
    preset(1'b0);
    check("R8 preset in divider mode", int'(div_out), 1);

    // R4/R5: event mode
    setup(2'b01, 2'd0, 8'd10);
    base = irq_cnt;
    for (int k = 0; k < 3; k++) evt_pulse(4, 4);
    idle(8);
    check("R4 three edges no match", irq_cnt - base, 0);
    write_cmp(8'd4);
    evt_pulse(4, 4); idle(8);
    check("R5 immediate compare", irq_cnt - base, 1);
    for (int k = 0; k < 5; k++) evt_pulse(1, 3);
    for (int k = 0; k < 3; k++) evt_pulse(4, 4);
    idle(8);
    check("R4 glitches ignored", irq_cnt - base, 1);
    evt_pulse(2, 2); idle(8);
    check("R4 minimum-width edge counted", irq_cnt - base, 2);
    preset(1'b1); idle(2);
    check("R8 preset ignored in event mode", int'(div_out), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule